// File: doc/BRIEF.md
# Super I/O configuration access controller

This block is the configuration front end of a legacy PC peripheral controller. It sits on a simple host I/O bus and watches an index/data port pair. While it is idle the pair answers reads with 0xFF and writes to the data port have no effect. Writing the entry key to the index port puts the block into configuration mode. Depending on a strap bit held in the register file, the key must be written once or twice in a row.

In configuration mode the host selects one of 42 byte registers by writing its number to the index port. It then reads or writes that register through the data port. A few registers are read-only and one has masked bits. A lock bit freezes the whole file against data writes and hides the lower registers from reads. The full contents are driven out as one flat vector for the downstream address and resource decode logic. Writing 0xAA to the index port leaves configuration mode.

Top module: `sio_cfg_ctrl`

## Requirements
- R1: After reset the block is out of configuration mode and the pointer is 0. Registers reset to: 0x03=0x30, 0x07=0xF5, 0x09=0x0A, 0x0A=0x1F, 0x0C=0x28, 0x0D=0xA3, 0x1E=0x81, 0x20=0xFC, 0x21=0x7C, 0x22=0xFD, 0x23=0xDE, 0x24=0xFE, 0x25=0xBE, 0x26=0x24, 0x27=0x67, 0x28=0x43, 0x29=0x62. Every other register resets to 0.
- R2: The strap is register 0x16 bit 0. When it is 0, the index port is 0x250 and the data port is 0x251. When it is 1, the index port is 0x3F0 and the data port is 0x3F1. Accesses to any other address have no effect, and a read of such an address returns 0xFF.
- R3: The entry key is 0x88 when the strap is 0 and 0x86 when the strap is 1, with bit 0 of the key replaced by register 0x0C bit 5.
- R4: With the strap at 0, one key write to the index port enters configuration mode. With the strap at 1, two key writes in a row are needed. Any other index write made outside configuration mode cancels a pending first key.
- R5: In configuration mode, writing 0xAA to the index port leaves configuration mode.
- R6: In configuration mode, an index write updates the pointer only when the value is below 0x2A.
- R7: Outside configuration mode, reads of either port return 0xFF. In configuration mode, an index-port read returns the pointer.
- R8: Data writes to registers 0x26, 0x27 and 0x29 are ignored. A data write to register 0x06 stores the value ANDed with 0xF3.
- R9: While register 0x09 bit 6 is set, all data writes are ignored. Data reads of registers below 0x18 return 0xFF, and data reads of higher registers return their contents. Index writes still move the pointer.
- R10: regs_o carries register n in bits [8n+7:8n]. Data writes made outside configuration mode leave it unchanged.
- R11: A change to the strap or to register 0x0C bit 5 applies to port decoding and key matching from the next host access onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Host I/O address |
| wdata_i | input | 8 | Host write data |
| wr_i | input | 1 | Write strobe, one byte per high cycle |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational |
| cfg_mode_o | output | 1 | High in configuration mode |
| regs_o | output | 336 | Flat register contents, register n in bits [8n+7:8n] |

## Verification
Several properties are checked on every cycle:
- reads outside configuration mode return 0xFF;
- the read-only registers never change and the masked bits of register 0x06 stay zero;
- the register vector holds still whenever the block is idle or locked;
- an index read never shows a pointer of 0x2A or above;
- 0xAA always leaves configuration mode.

The rest depends on ordered traffic, and only the bench scenarios show it:
- the key sequences, single and double, and a pending first key being cancelled;
- the key low bit taken from register 0x0C;
- the port move when the strap changes;
- the read masking under the lock.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int NUM_REGS   = 42;
  localparam int PTR_W      = $clog2(NUM_REGS);
  localparam int REG_MASKED = 6;
  localparam int REG_LOCK   = 9;
  localparam int LOCK_BIT   = 6;
  localparam int REG_KEYSEL = 12;
  localparam int KEYSEL_BIT = 5;
  localparam int REG_STRAP  = 22;
  localparam int STRAP_BIT  = 0;
  localparam int LOCK_RD_LIM = 24;
  localparam logic [7:0] EXIT_CODE = 8'hAA;
  localparam logic [7:0] IDLE_READ = 8'hFF;

  typedef logic [7:0] cfg_byte_t;

  function automatic cfg_byte_t cfg_rst_val(input int idx);
    case (idx)
      3:  return 8'h30;
      7:  return 8'hF5;
      9:  return 8'h0A;
      10: return 8'h1F;
      12: return 8'h28;
      13: return 8'hA3;
      30: return 8'h81;
      32: return 8'hFC;
      33: return 8'h7C;
      34: return 8'hFD;
      35: return 8'hDE;
      36: return 8'hFE;
      37: return 8'hBE;
      38: return 8'h24;
      39: return 8'h67;
      40: return 8'h43;
      41: return 8'h62;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit cfg_writable(input int idx);
    return !(idx == 38 || idx == 39 || idx == 41);
  endfunction

  function automatic cfg_byte_t cfg_wr_mask(input int idx);
    return (idx == REG_MASKED) ? 8'hF3 : 8'hFF;
  endfunction
endpackage

// File: rtl/sio_cfg_port_dec.sv
module sio_cfg_port_dec #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE_LO = 12'h250,
  parameter logic [ADDR_W-1:0] BASE_HI = 12'h3F0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strap_i,
  output logic              idx_hit_o,
  output logic              dat_hit_o
);
  logic [ADDR_W-1:0] base;

  assign base      = strap_i ? BASE_HI : BASE_LO;
  assign idx_hit_o = (addr_i == base);
  assign dat_hit_o = (addr_i == (base | ADDR_W'(1)));
endmodule

// File: rtl/sio_cfg_entry.sv
module sio_cfg_entry
  import sio_cfg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      idx_wr_i,
  input  cfg_byte_t wdata_i,
  input  logic      strap_i,
  input  logic      keysel_i,
  output logic      cfg_mode_o
);
  logic      mode_q, half_q;
  cfg_byte_t key;

  // strap=1 selects the 0x86 family and a double write
  assign key = strap_i ? {7'h43, keysel_i} : {7'h44, keysel_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      half_q <= 1'b0;
    end else if (idx_wr_i) begin
      if (!mode_q) begin
        if (wdata_i == key) begin
          if (strap_i && !half_q) begin
            half_q <= 1'b1;
          end else begin
            mode_q <= 1'b1;
            half_q <= 1'b0;
          end
        end else begin
          half_q <= 1'b0;
        end
      end else if (wdata_i == EXIT_CODE) begin
        mode_q <= 1'b0;
      end
    end
  end

  assign cfg_mode_o = mode_q;
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [PTR_W-1:0]      ptr_i,
  input  cfg_byte_t             wdata_i,
  output logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (cfg_writable(g)) begin : g_rw
      cfg_byte_t q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= cfg_rst_val(g);
        else if (we_i && ptr_i == PTR_W'(g)) q <= wdata_i & cfg_wr_mask(g);
      end
      assign regs_o[g*8 +: 8] = q;
    end else begin : g_ro
      assign regs_o[g*8 +: 8] = cfg_rst_val(g);
    end
  end
endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  output logic [7:0]            rdata_o,
  output logic                  cfg_mode_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam logic [7:0]       NUM_REGS_B = 8'(NUM_REGS);
  localparam logic [PTR_W-1:0] LOCK_LIM   = PTR_W'(LOCK_RD_LIM);

  logic             idx_hit, dat_hit, strap, keysel, lock;
  logic             idx_wr, dat_we;
  logic [PTR_W-1:0] ptr_q;
  cfg_byte_t        sel_byte;

  assign strap  = regs_o[REG_STRAP*8 + STRAP_BIT];
  assign keysel = regs_o[REG_KEYSEL*8 + KEYSEL_BIT];
  assign lock   = regs_o[REG_LOCK*8 + LOCK_BIT];

  sio_cfg_port_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i    (addr_i),
    .strap_i   (strap),
    .idx_hit_o (idx_hit),
    .dat_hit_o (dat_hit)
  );

  assign idx_wr = wr_i && idx_hit;
  assign dat_we = wr_i && dat_hit && cfg_mode_o && !lock;

  sio_cfg_entry u_entry (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (idx_wr),
    .wdata_i    (wdata_i),
    .strap_i    (strap),
    .keysel_i   (keysel),
    .cfg_mode_o (cfg_mode_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (idx_wr && cfg_mode_o && wdata_i < NUM_REGS_B) ptr_q <= wdata_i[PTR_W-1:0];
  end

  sio_cfg_regfile u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (dat_we),
    .ptr_i   (ptr_q),
    .wdata_i (wdata_i),
    .regs_o  (regs_o)
  );

  always_comb begin
    sel_byte = IDLE_READ;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr_q == PTR_W'(i)) sel_byte = regs_o[i*8 +: 8];
  end

  always_comb begin
    rdata_o = IDLE_READ;
    if (rd_i && cfg_mode_o) begin
      if (idx_hit)      rdata_o = 8'(ptr_q);
      else if (dat_hit) rdata_o = (lock && ptr_q < LOCK_LIM) ? IDLE_READ : sel_byte;
    end
  end
endmodule

// File: rtl/sio_cfg_ctrl_chk.sv
module sio_cfg_ctrl_chk
  import sio_cfg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [7:0]            wdata_i,
  input logic                  wr_i,
  input logic                  rd_i,
  input logic [7:0]            rdata_o,
  input logic                  cfg_mode_o,
  input logic [NUM_REGS*8-1:0] regs_o
);
  logic [ADDR_W-1:0] idx_addr;
  logic              locked;

  assign idx_addr = regs_o[REG_STRAP*8 + STRAP_BIT] ? ADDR_W'(12'h3F0) : ADDR_W'(12'h250);
  assign locked   = regs_o[REG_LOCK*8 + LOCK_BIT];

  // R7
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_mode_o && rd_i) |-> rdata_o == 8'hFF);

  // R6
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && rd_i && addr_i == idx_addr) |-> rdata_o < 8'd42);

  // R8
  ro_regs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(regs_o[38*8 +: 16]) && $stable(regs_o[41*8 +: 8]));

  // R8
  masked_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_o[REG_MASKED*8 + 2 +: 2] == 2'b00);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_o |=> $stable(regs_o));

  // R9
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> $stable(regs_o));

  // R5
  exit_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_o && wr_i && addr_i == idx_addr && wdata_i == 8'hAA) |=> !cfg_mode_o);
endmodule

bind sio_cfg_ctrl sio_cfg_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .rdata_o    (rdata_o),
  .cfg_mode_o (cfg_mode_o),
  .regs_o     (regs_o)
);

// File: tb/sio_cfg_ctrl_bench.sv
module sio_cfg_ctrl_bench;
  localparam logic [11:0] IDX0 = 12'h250, DAT0 = 12'h251;
  localparam logic [11:0] IDX1 = 12'h3F0, DAT1 = 12'h3F1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [11:0]  addr = '0;
  logic [7:0]   wdata = '0;
  logic         wr = 1'b0, rd = 1'b0;
  logic [7:0]   rdata;
  logic         cfg_mode;
  logic [335:0] regs;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sio_cfg_ctrl u_sio_cfg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .cfg_mode_o(cfg_mode), .regs_o(regs)
  );

  function automatic logic [7:0] reg_of(input int n);
    return regs[n*8 +: 8];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #2 d = rdata; rd = 1'b0;
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 mode", {7'b0, cfg_mode}, 8'h00);
    chk("R1 reg23", reg_of(35), 8'hDE);
    chk("R1 reg28", reg_of(40), 8'h43);
    chk("R1 reg16", reg_of(22), 8'h00);
    chk("R1 reg0D", reg_of(13), 8'hA3);
    bus_rd(IDX0, d); chk("R7 idle idx read", d, 8'hFF);
    bus_rd(DAT0, d); chk("R7 idle dat read", d, 8'hFF);
  endtask

  task automatic t_single_key();
    logic [7:0] d;
    bus_wr(IDX0, 8'h88); chk("R3 wrong key", {7'b0, cfg_mode}, 8'h00);
    bus_wr(DAT0, 8'h55); chk("R10 idle data write", reg_of(0), 8'h00);
    bus_wr(IDX0, 8'h89); chk("R4 single key", {7'b0, cfg_mode}, 8'h01);
    bus_rd(IDX0, d); chk("R1 ptr reset", d, 8'h00);
    bus_wr(IDX0, 8'h23); bus_rd(DAT0, d); chk("R7 data read", d, 8'hDE);
  endtask

  task automatic t_pointer();
    logic [7:0] d;
    bus_wr(IDX0, 8'h29); bus_rd(IDX0, d); chk("R6 ptr 0x29", d, 8'h29);
    bus_wr(IDX0, 8'h2A); bus_rd(IDX0, d); chk("R6 ptr 0x2A rejected", d, 8'h29);
    bus_wr(IDX0, 8'h50); bus_rd(IDX0, d); chk("R6 ptr 0x50 rejected", d, 8'h29);
  endtask

  task automatic t_write_rules();
    logic [7:0] d;
    bus_wr(IDX0, 8'h26); bus_wr(DAT0, 8'h55); bus_rd(DAT0, d); chk("R8 reg26", d, 8'h24);
    bus_wr(IDX0, 8'h27); bus_wr(DAT0, 8'h00); chk("R8 reg27", reg_of(39), 8'h67);
    bus_wr(IDX0, 8'h29); bus_wr(DAT0, 8'h00); chk("R8 reg29", reg_of(41), 8'h62);
    bus_wr(IDX0, 8'h06); bus_wr(DAT0, 8'hFF); bus_rd(DAT0, d); chk("R8 reg6 mask", d, 8'hF3);
    bus_wr(IDX0, 8'h10); bus_wr(DAT0, 8'hA5); bus_rd(DAT0, d); chk("R10 rw readback", d, 8'hA5);
    chk("R10 export", reg_of(16), 8'hA5);
  endtask

  task automatic t_other_addr();
    logic [7:0] d;
    bus_wr(IDX1, 8'hAA); chk("R2 foreign addr ignored", {7'b0, cfg_mode}, 8'h01);
    bus_rd(12'h3F1, d); chk("R2 foreign read", d, 8'hFF);
    bus_wr(DAT1, 8'h00); chk("R2 foreign write", reg_of(16), 8'hA5);
  endtask

  task automatic t_exit();
    logic [7:0] d;
    bus_wr(IDX0, 8'hAA); chk("R5 exit", {7'b0, cfg_mode}, 8'h00);
    bus_rd(DAT0, d); chk("R7 read after exit", d, 8'hFF);
    bus_wr(DAT0, 8'h11); chk("R10 write after exit", reg_of(16), 8'hA5);
  endtask

  task automatic t_keysel();
    bus_wr(IDX0, 8'h89);
    bus_wr(IDX0, 8'h0C); bus_wr(DAT0, 8'h08);
    bus_wr(IDX0, 8'hAA);
    bus_wr(IDX0, 8'h89); chk("R11 old key dead", {7'b0, cfg_mode}, 8'h00);
    bus_wr(IDX0, 8'h88); chk("R3 key bit from reg0C", {7'b0, cfg_mode}, 8'h01);
  endtask

  task automatic t_strap();
    logic [7:0] d;
    bus_wr(IDX0, 8'h16); bus_wr(DAT0, 8'h01);
    bus_rd(DAT0, d); chk("R11 old port gone", d, 8'hFF);
    bus_rd(IDX1, d); chk("R2 new index port", d, 8'h16);
    bus_wr(IDX1, 8'h0C); bus_wr(DAT1, 8'h28);
    bus_wr(IDX1, 8'hAA); chk("R5 exit new port", {7'b0, cfg_mode}, 8'h00);
    bus_wr(IDX1, 8'h87); chk("R4 first key only", {7'b0, cfg_mode}, 8'h00);
    bus_wr(IDX1, 8'h00);
    bus_wr(IDX1, 8'h87); chk("R4 partial cleared", {7'b0, cfg_mode}, 8'h00);
    bus_wr(IDX1, 8'h87); chk("R4 double key", {7'b0, cfg_mode}, 8'h01);
  endtask

  task automatic t_lock();
    logic [7:0] d;
    bus_wr(IDX1, 8'h09); bus_wr(DAT1, 8'h4A);
    bus_wr(IDX1, 8'h10); bus_rd(DAT1, d); chk("R9 low read hidden", d, 8'hFF);
    bus_wr(IDX1, 8'h20); bus_rd(DAT1, d); chk("R9 high read open", d, 8'hFC);
    bus_wr(DAT1, 8'h00); bus_rd(DAT1, d); chk("R9 write ignored", d, 8'hFC);
    bus_rd(IDX1, d); chk("R9 ptr still moves", d, 8'h20);
    apply_reset();
    chk("R1 reset after lock", reg_of(9), 8'h0A);
    chk("R1 mode after reset", {7'b0, cfg_mode}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single_key();
    t_pointer();
    t_write_rules();
    t_other_addr();
    t_exit();
    t_keysel();
    t_strap();
    t_lock();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule